// File: doc/BRIEF.md
# Trap Entry and Reset Sequencer

This block computes the processor-state change that happens when a trap is taken or when the processor is reset. It accepts a trap request with an 8-bit type code, a separate misaligned-access fault, and a reset request. It also accepts the pre-trap program counter (PC), the next program counter (nPC) and the state fields: trap enable, supervisor, previous supervisor and current window pointer. One clock later it presents the new PC, nPC and state fields together with a single-cycle update strobe.

On trap entry only reversible changes are made. Traps are disabled, the old supervisor bit moves into the previous-supervisor bit, and the window pointer steps down by one modulo the window count. The pre-trap PC and nPC are handed to the register file as writes to locals 1 and 2 of the new window. The block owns a trap base register made of a software-written base and a hardware-written type field. The entry vector is that register's value, so each trap type lands in its own 16-byte slot.

A synchronous trap raised while traps are disabled does not vector. It latches an error mode that only a reset request clears. An asynchronous trap raised while traps are disabled is dropped.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After rst_ni is released, upd_o, loc_we_o and err_mode_o are 0, tbr_o is 0, and pc_o, npc_o and the state outputs are 0.
- R2: One cycle after an accepted trap, upd_o is 1, et_o is 0, s_o is 1, and ps_o equals the s_i value sampled with the trap.
- R3: On trap entry cwp_o equals the sampled cwp_i minus one modulo NWIN. A cwp_i of 0 gives NWIN-1. No invalid-window check is made.
- R4: On trap entry loc_we_o pulses for one cycle, loc_win_o equals the new cwp_o, loc1_data_o holds the sampled pc_i and loc2_data_o holds the sampled npc_i.
- R5: On trap entry the type field tbr_o[11:4] takes the trap type, and tbr_o[3:0] reads 0. pc_o becomes the new tbr_o value and npc_o becomes pc_o plus 4.
- R6: A base write (tbr_base_we_i) loads tbr_o[31:12] on the next edge and keeps the type field. If a trap is accepted on the same edge, its vector already uses the new base.
- R7: A reset request (reset_req_i) has precedence over every trap source. One cycle later it gives upd_o=1, pc_o=0, npc_o=4, et_o=0 and s_o=1, with ps_o and cwp_o equal to the sampled ps_i and cwp_i. It gives loc_we_o=0 and leaves tbr_o unchanged.
- R8: A synchronous trap (trap_sync_i=1 or align_fault_i=1) while et_i=0 sets err_mode_o. It produces no upd_o, no loc_we_o and no tbr_o change.
- R9: While err_mode_o is 1, all trap requests are ignored and err_mode_o stays 1. A reset request clears it on the next edge.
- R10: An asynchronous trap (trap_sync_i=0) while et_i=0 is ignored: upd_o, loc_we_o, err_mode_o and tbr_o do not change.
- R11: align_fault_i raises a synchronous trap with type 7 (tbr_o[11:4]=8'h07) and has precedence over trap_req_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reset_req_i | input | 1 | Processor reset request |
| trap_req_i | input | 1 | Trap request |
| trap_sync_i | input | 1 | 1: request is synchronous, 0: asynchronous |
| trap_type_i | input | 8 | Trap type of trap_req_i |
| align_fault_i | input | 1 | Misaligned access fault (synchronous, type 7) |
| pc_i | input | 32 | Pre-trap PC |
| npc_i | input | 32 | Pre-trap nPC |
| et_i | input | 1 | Current trap enable |
| s_i | input | 1 | Current supervisor bit |
| ps_i | input | 1 | Current previous-supervisor bit |
| cwp_i | input | CWP_W | Current window pointer |
| tbr_base_we_i | input | 1 | Write enable for the trap base field |
| tbr_base_i | input | 20 | New trap base value |
| upd_o | output | 1 | New state valid (one-cycle pulse) |
| pc_o | output | 32 | New PC |
| npc_o | output | 32 | New nPC |
| et_o | output | 1 | New trap enable |
| s_o | output | 1 | New supervisor bit |
| ps_o | output | 1 | New previous-supervisor bit |
| cwp_o | output | CWP_W | New window pointer |
| loc_we_o | output | 1 | Write strobe for locals 1 and 2 |
| loc_win_o | output | CWP_W | Window receiving the local writes |
| loc1_data_o | output | 32 | Saved PC for local 1 |
| loc2_data_o | output | 32 | Saved nPC for local 2 |
| tbr_o | output | 32 | Trap base register |
| err_mode_o | output | 1 | Sticky error mode |

## Verification
Traps are driven with different type codes and window pointers. The pointer values include 0, which separates a modulo wrap from a plain decrement, and distinct s_i and ps_i values show whether the supervisor bit was copied or simply passed through. A fault and a trap request on the same edge, a base write on the same edge as a trap, and a reset request together with a trap show which source wins and which base the vector uses. With et_i low, an asynchronous trap and a synchronous trap are driven to separate the drop case from the error case. A later trap and a reset request then show that error mode is sticky and that only a reset clears it.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  localparam int unsigned TT_W      = 8;
  localparam int unsigned SLOT_LSB  = 4;
  localparam logic [TT_W-1:0] TT_MISALIGN = 8'h07;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_RESET = 2'd1,
    ACT_ENTER = 2'd2,
    ACT_ERROR = 2'd3
  } trap_act_e;
endpackage

// File: rtl/trap_classify.sv
module trap_classify
  import trap_seq_pkg::*;
(
  input  logic            reset_req_i,
  input  logic            trap_req_i,
  input  logic            trap_sync_i,
  input  logic [TT_W-1:0] trap_type_i,
  input  logic            align_fault_i,
  input  logic            et_i,
  input  logic            err_q_i,
  output trap_act_e       act_o,
  output logic [TT_W-1:0] eff_tt_o
);
  logic any_trap, is_sync;

  assign any_trap = trap_req_i | align_fault_i;
  assign is_sync  = align_fault_i | trap_sync_i;
  assign eff_tt_o = align_fault_i ? TT_MISALIGN : trap_type_i;

  always_comb begin
    act_o = ACT_NONE;
    if (reset_req_i)             act_o = ACT_RESET;
    else if (err_q_i)            act_o = ACT_NONE;
    else if (any_trap && et_i)   act_o = ACT_ENTER;
    else if (any_trap && is_sync) act_o = ACT_ERROR;
  end
endmodule

// File: rtl/trap_tbr.sv
module trap_tbr
  import trap_seq_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  localparam int unsigned BASE_W = XLEN - TT_W - SLOT_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              tt_we_i,
  input  logic [TT_W-1:0]   tt_i,
  output logic [BASE_W-1:0] base_nxt_o,
  output logic [XLEN-1:0]   tbr_o
);
  logic [BASE_W-1:0] base_q;
  logic [TT_W-1:0]   tt_q;

  assign base_nxt_o = base_we_i ? base_i : base_q;
  assign tbr_o      = {base_q, tt_q, {SLOT_LSB{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      tt_q   <= '0;
    end else begin
      base_q <= base_nxt_o;
      if (tt_we_i) tt_q <= tt_i;
    end
  end
endmodule

// File: rtl/trap_state_calc.sv
module trap_state_calc
  import trap_seq_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NWIN  = 8,
  localparam int unsigned CWP_W  = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int unsigned BASE_W = XLEN - TT_W - SLOT_LSB
) (
  input  logic              is_reset_i,
  input  logic              s_i,
  input  logic              ps_i,
  input  logic [CWP_W-1:0]  cwp_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [TT_W-1:0]   tt_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   npc_o,
  output logic              et_o,
  output logic              s_o,
  output logic              ps_o,
  output logic [CWP_W-1:0]  cwp_o
);
  logic [CWP_W-1:0] cwp_dec;
  logic [XLEN-1:0]  vec;

  generate
    if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
      assign cwp_dec = cwp_i - 1'b1;
    end else begin : g_wrap
      assign cwp_dec = (cwp_i == '0) ? CWP_W'(NWIN - 1) : cwp_i - 1'b1;
    end
  endgenerate

  assign vec = {base_i, tt_i, {SLOT_LSB{1'b0}}};

  always_comb begin
    et_o = 1'b0;
    s_o  = 1'b1;
    if (is_reset_i) begin
      pc_o  = '0;
      npc_o = XLEN'(4);
      ps_o  = ps_i;
      cwp_o = cwp_i;
    end else begin
      pc_o  = vec;
      npc_o = vec + XLEN'(4);
      ps_o  = s_i;
      cwp_o = cwp_dec;
    end
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_seq_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NWIN = 8,
  localparam int unsigned CWP_W  = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int unsigned BASE_W = XLEN - TT_W - SLOT_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reset_req_i,
  input  logic              trap_req_i,
  input  logic              trap_sync_i,
  input  logic [TT_W-1:0]   trap_type_i,
  input  logic              align_fault_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   npc_i,
  input  logic              et_i,
  input  logic              s_i,
  input  logic              ps_i,
  input  logic [CWP_W-1:0]  cwp_i,
  input  logic              tbr_base_we_i,
  input  logic [BASE_W-1:0] tbr_base_i,
  output logic              upd_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   npc_o,
  output logic              et_o,
  output logic              s_o,
  output logic              ps_o,
  output logic [CWP_W-1:0]  cwp_o,
  output logic              loc_we_o,
  output logic [CWP_W-1:0]  loc_win_o,
  output logic [XLEN-1:0]   loc1_data_o,
  output logic [XLEN-1:0]   loc2_data_o,
  output logic [XLEN-1:0]   tbr_o,
  output logic              err_mode_o
);
  trap_act_e         act;
  logic [TT_W-1:0]   eff_tt;
  logic [BASE_W-1:0] base_nxt;
  logic [XLEN-1:0]   nx_pc, nx_npc;
  logic              nx_et, nx_s, nx_ps;
  logic [CWP_W-1:0]  nx_cwp;
  logic              is_enter, is_reset;

  assign is_enter = (act == ACT_ENTER);
  assign is_reset = (act == ACT_RESET);

  trap_classify u_cls (
    .reset_req_i  (reset_req_i),
    .trap_req_i   (trap_req_i),
    .trap_sync_i  (trap_sync_i),
    .trap_type_i  (trap_type_i),
    .align_fault_i(align_fault_i),
    .et_i         (et_i),
    .err_q_i      (err_mode_o),
    .act_o        (act),
    .eff_tt_o     (eff_tt)
  );

  trap_tbr #(.XLEN(XLEN)) u_tbr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .base_we_i (tbr_base_we_i),
    .base_i    (tbr_base_i),
    .tt_we_i   (is_enter),
    .tt_i      (eff_tt),
    .base_nxt_o(base_nxt),
    .tbr_o     (tbr_o)
  );

  trap_state_calc #(.XLEN(XLEN), .NWIN(NWIN)) u_calc (
    .is_reset_i(is_reset),
    .s_i       (s_i),
    .ps_i      (ps_i),
    .cwp_i     (cwp_i),
    .base_i    (base_nxt),
    .tt_i      (eff_tt),
    .pc_o      (nx_pc),
    .npc_o     (nx_npc),
    .et_o      (nx_et),
    .s_o       (nx_s),
    .ps_o      (nx_ps),
    .cwp_o     (nx_cwp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_o       <= 1'b0;
      loc_we_o    <= 1'b0;
      err_mode_o  <= 1'b0;
      pc_o        <= '0;
      npc_o       <= '0;
      et_o        <= 1'b0;
      s_o         <= 1'b0;
      ps_o        <= 1'b0;
      cwp_o       <= '0;
      loc_win_o   <= '0;
      loc1_data_o <= '0;
      loc2_data_o <= '0;
    end else begin
      upd_o    <= is_enter | is_reset;
      loc_we_o <= is_enter;
      if (is_reset)              err_mode_o <= 1'b0;
      else if (act == ACT_ERROR) err_mode_o <= 1'b1;
      if (is_enter | is_reset) begin
        pc_o  <= nx_pc;
        npc_o <= nx_npc;
        et_o  <= nx_et;
        s_o   <= nx_s;
        ps_o  <= nx_ps;
        cwp_o <= nx_cwp;
      end
      if (is_enter) begin
        loc_win_o   <= nx_cwp;
        loc1_data_o <= pc_i;
        loc2_data_o <= npc_i;
      end
    end
  end
endmodule

// File: rtl/trap_entry_ctrl_chk.sv
module trap_entry_ctrl_chk #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NWIN  = 8,
  parameter int unsigned CWP_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reset_req_i,
  input logic [CWP_W-1:0] cwp_i,
  input logic             upd_o,
  input logic [XLEN-1:0]  pc_o,
  input logic [XLEN-1:0]  npc_o,
  input logic             et_o,
  input logic             s_o,
  input logic [CWP_W-1:0] cwp_o,
  input logic             loc_we_o,
  input logic [CWP_W-1:0] loc_win_o,
  input logic [XLEN-1:0]  tbr_o,
  input logic             err_mode_o
);
  // R2
  enter_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_we_o |-> (upd_o && !et_o && s_o));
  // R3
  win_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_we_o |-> (cwp_o == (($past(cwp_i) == '0) ? CWP_W'(NWIN - 1) : $past(cwp_i) - 1'b1)));
  // R4
  loc_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_we_o |-> (loc_win_o == cwp_o));
  // R5
  vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_we_o |-> (pc_o == tbr_o && npc_o == tbr_o + XLEN'(4) && tbr_o[3:0] == 4'h0));
  // R7
  reset_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_o && !loc_we_o) |-> (pc_o == '0 && npc_o == XLEN'(4) && s_o && !et_o));
  // R8
  err_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_mode_o |-> !loc_we_o);
  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_mode_o && !reset_req_i) |=> err_mode_o);
  // R9
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_i |=> !err_mode_o);
endmodule

bind trap_entry_ctrl trap_entry_ctrl_chk #(.XLEN(XLEN), .NWIN(NWIN), .CWP_W(CWP_W)) u_chk (.*);

// File: tb/trap_entry_ctrl_test.sv
`timescale 1ns/1ps
module trap_entry_ctrl_test;
  localparam int unsigned XLEN = 32;
  localparam int unsigned NWIN = 8;
  localparam int unsigned CWP_W = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic reset_req, trap_req, trap_sync, align_fault, et, s, ps, base_we;
  logic [7:0] ttype;
  logic [31:0] pc, npc;
  logic [CWP_W-1:0] cwp;
  logic [19:0] base;

  logic upd, et_q, s_q, ps_q, lwe, err;
  logic [31:0] pc_q, npc_q, l1, l2, tbr;
  logic [CWP_W-1:0] cwp_q, lwin;

  always #4 clk = ~clk;

  trap_entry_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .reset_req_i(reset_req), .trap_req_i(trap_req),
    .trap_sync_i(trap_sync), .trap_type_i(ttype), .align_fault_i(align_fault),
    .pc_i(pc), .npc_i(npc), .et_i(et), .s_i(s), .ps_i(ps), .cwp_i(cwp),
    .tbr_base_we_i(base_we), .tbr_base_i(base),
    .upd_o(upd), .pc_o(pc_q), .npc_o(npc_q), .et_o(et_q), .s_o(s_q), .ps_o(ps_q),
    .cwp_o(cwp_q), .loc_we_o(lwe), .loc_win_o(lwin), .loc1_data_o(l1),
    .loc2_data_o(l2), .tbr_o(tbr), .err_mode_o(err)
  );

  typedef struct {
    bit upd; bit [31:0] pc; bit [31:0] npc; bit et; bit s; bit ps; bit [2:0] cwp;
    bit lwe; bit [2:0] lwin; bit [31:0] l1; bit [31:0] l2; bit [31:0] tbr; bit err;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t m;
  bit [19:0] m_base;
  bit [7:0]  m_tt;
  int n_tests = 0;
  int n_fail = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "flags", {upd, lwe, err}, {e.upd, e.lwe, e.err});
      chk(e.tag, "pc/npc", {pc_q, npc_q}, {e.pc, e.npc});
      chk(e.tag, "state", {et_q, s_q, ps_q, cwp_q}, {e.et, e.s, e.ps, e.cwp});
      chk(e.tag, "locals", {lwin, l1, l2}, {e.lwin, e.l1, e.l2});
      chk(e.tag, "tbr", tbr, e.tbr);
    end
  end

  // driver: one edge per call, expectation pushed after the edge
  task automatic step(string tag, bit rq, bit tr, bit sy, bit [7:0] tt, bit af,
                      bit [31:0] p, bit [31:0] np, bit e_i, bit s_v, bit ps_v,
                      bit [2:0] w, bit bwe, bit [19:0] b);
    bit [7:0] ety;
    @(negedge clk);
    reset_req = rq; trap_req = tr; trap_sync = sy; ttype = tt; align_fault = af;
    pc = p; npc = np; et = e_i; s = s_v; ps = ps_v; cwp = w; base_we = bwe; base = b;
    m.upd = 0; m.lwe = 0;
    if (bwe) m_base = b;
    if (rq) begin
      m.upd = 1; m.pc = 0; m.npc = 4; m.et = 0; m.s = 1; m.ps = ps_v; m.cwp = w; m.err = 0;
    end else if (!m.err && (tr || af)) begin
      ety = af ? 8'h07 : tt;
      if (e_i) begin
        m_tt = ety;
        m.upd = 1; m.pc = {m_base, ety, 4'h0}; m.npc = m.pc + 4;
        m.et = 0; m.s = 1; m.ps = s_v; m.cwp = 3'((w + NWIN - 1) % NWIN);
        m.lwe = 1; m.lwin = m.cwp; m.l1 = p; m.l2 = np;
      end else if (af || sy) begin
        m.err = 1;
      end
    end
    m.tbr = {m_base, m_tt, 4'h0};
    m.tag = tag;
    @(posedge clk);
    #1;
    q.push_back(m);
    reset_req = 0; trap_req = 0; align_fault = 0; base_we = 0;
  endtask

  initial begin
    reset_req = 0; trap_req = 0; trap_sync = 0; ttype = 0; align_fault = 0;
    pc = 0; npc = 0; et = 0; s = 0; ps = 0; cwp = 0; base_we = 0; base = 0;
    m = '{default: 0, tag: ""};
    m_base = 0; m_tt = 0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    step("R1 reset state", 0,0,0,8'h00,0, 32'h0,32'h0, 0,0,0,3'd0, 0,20'h0);
    step("R6 base write", 0,0,0,8'h00,0, 32'h0,32'h0, 1,0,0,3'd0, 1,20'hABCDE);
    step("R2 R4 R5 async trap", 0,1,0,8'h11,0, 32'h0000_1000,32'h0000_1004, 1,0,1,3'd5, 0,20'h0);
    step("R3 wrap at window 0", 0,1,1,8'h2A,0, 32'h0000_2000,32'h0000_2008, 1,1,0,3'd0, 0,20'h0);
    step("R11 fault beats request", 0,1,0,8'h40,1, 32'h0000_3002,32'h0000_3006, 1,1,1,3'd7, 0,20'h0);
    step("R6 base write with trap", 0,1,1,8'hFF,0, 32'h0000_4000,32'h0000_4004, 1,0,0,3'd1, 1,20'h12345);
    step("R7 reset beats trap", 1,1,1,8'h33,0, 32'h0000_5000,32'h0000_5004, 1,0,1,3'd6, 0,20'h0);
    step("R10 async with traps off", 0,1,0,8'h21,0, 32'h0000_6000,32'h0000_6004, 0,1,0,3'd3, 0,20'h0);
    step("R8 sync with traps off", 0,1,1,8'h05,0, 32'h0000_7000,32'h0000_7004, 0,1,0,3'd3, 0,20'h0);
    step("R9 trap ignored in error", 0,1,1,8'h09,0, 32'h0000_8000,32'h0000_8004, 1,1,0,3'd2, 0,20'h0);
    step("R9 fault ignored in error", 0,0,0,8'h00,1, 32'h0000_8100,32'h0000_8104, 1,1,0,3'd2, 0,20'h0);
    step("R9 R7 reset clears error", 1,0,0,8'h00,0, 32'h0,32'h0, 0,0,0,3'd4, 0,20'h0);
    step("R8 fault with traps off", 0,0,0,8'h00,1, 32'h0000_9000,32'h0000_9004, 0,0,0,3'd4, 0,20'h0);
    step("R9 R7 reset clears again", 1,0,0,8'h00,0, 32'h0,32'h0, 0,1,1,3'd2, 0,20'h0);
    step("R2 R3 R5 trap after recovery", 0,1,1,8'h80,0, 32'h0000_A000,32'h0000_A004, 1,1,0,3'd2, 0,20'h0);
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule